// File: doc/BRIEF.md
# Low-Speed Compare Timer with Wake-Up

This block is a 16-bit up-counter that advances on single-cycle tick pulses from a slow oscillator. It compares the count with a 16-bit match value. Software writes that value as two bytes through a small byte-wide register port. When the count reaches the match value, a sticky flag is set and the count starts again from zero. The match period is therefore the match value plus one ticks.

The flag drives two outputs, each with its own gating. The interrupt request is qualified by an external global enable and by a local interrupt enable. The wake request to the power controller is qualified by the timer enable, the count enable and the wake enable. A separate register holds a single priority bit, which is passed straight to the interrupt controller.

The wake output depends only on state that the tick-domain logic holds. It does not need the CPU clock, so it can rouse a sleeping system.

Top module: `lstmr_top`

## Requirements
- R1: After reset every register reads 0. `irq_o`, `wake_o` and `prio_o` are 0, and the counter is stopped at zero.
- R2: The counter runs only while the timer enable (control bit 0) and the count enable (control bit 1) are both 1. It adds one on each cycle where `lsi_tick` is 1. When the count enable is 0, it holds its value. When the timer enable is 0, it is forced to zero.
- R3: On a counting tick where the count equals the match value, the flag is set at that edge. The count goes back to zero at the same edge, so matches recur every match+1 ticks. The match value is {high byte at address 2, low byte at address 1}.
- R4: The flag is control bit 4. It stays set until a control write (address 0) has bit 4 = 0. Writing 1 to bit 4 leaves the flag unchanged. If a match and a clearing write occur in the same cycle, the flag stays set.
- R5: `irq_o` is 1 exactly when the flag, `gie_i` and the interrupt enable (control bit 3) are all 1.
- R6: `wake_o` is 1 exactly when the flag, the timer enable, the count enable and the wake enable (control bit 2) are all 1.
- R7: In the priority register (address 3), only bit 2 is stored. `prio_o` follows that bit, with 1 meaning high priority. Every other bit reads 0, and writes to those bits are ignored.
- R8: A write to a match byte takes effect for the next compare. With a match value of 0, the flag is set on the first counting tick after reset.
- R9: Reading address 0 returns {000, flag, interrupt enable, wake enable, count enable, timer enable} from bit 7 down to bit 0. The match bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsi_tick | input | 1 | One-cycle pulse from the slow oscillator |
| gie_i | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request to the power controller |
| prio_o | output | 1 | Priority select, 1 = high |

## Verification
The hardest case to reach is a match landing in the same cycle as a clearing write. It needs the hidden count to equal the match value on exactly the cycle of the write. The bench reaches it directly by setting the match value to zero, so every counting tick is a match, and then issuing a control write with bit 4 low together with a tick. The random phase keeps match values small so that matches, clears and enable changes collide often, and a bench model tracks the count to predict each one.

// File: rtl/lstmr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the low-speed compare timer.
// Assumes a byte-wide register port with four registers.
package lstmr_pkg;
    localparam int ADDR_W   = 2;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_MLO   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_MHI   = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_PRIO  = 2'd3;
    localparam int BIT_TEN  = 0;
    localparam int BIT_CEN  = 1;
    localparam int BIT_WEN  = 2;
    localparam int BIT_IEN  = 3;
    localparam int BIT_FLAG = 4;
endpackage

// File: rtl/lstmr_regs.sv
`timescale 1ns/1ps
// Register file: control enables, match bytes and priority bit.
// Assumes a single write strobe; reads are combinational from addr.
module lstmr_regs
    import lstmr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PRIO_BIT = 2,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output logic              tmr_en,
    output logic              cnt_en,
    output logic              wake_en,
    output logic              irq_en,
    output logic [CNT_W-1:0]  match,
    output logic              prio_hi,
    output logic              flag_clr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mlo, mhi;

    // Store software writes; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_en  <= 1'b0;
            cnt_en  <= 1'b0;
            wake_en <= 1'b0;
            irq_en  <= 1'b0;
            mlo     <= '0;
            mhi     <= '0;
            prio_hi <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                ADR_CTRL: begin
                    tmr_en  <= wdata[BIT_TEN];
                    cnt_en  <= wdata[BIT_CEN];
                    wake_en <= wdata[BIT_WEN];
                    irq_en  <= wdata[BIT_IEN];
                end
                ADR_MLO:  mlo     <= wdata;
                ADR_MHI:  mhi     <= wdata;
                default:  prio_hi <= wdata[PRIO_BIT];
            endcase
        end
    end

    assign match    = {mhi, mlo};
    assign flag_clr = wr_en && (addr == ADR_CTRL) && !wdata[BIT_FLAG];

    // Read multiplexer with zero fill for unused bits.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: begin
                rdata[BIT_TEN]  = tmr_en;
                rdata[BIT_CEN]  = cnt_en;
                rdata[BIT_WEN]  = wake_en;
                rdata[BIT_IEN]  = irq_en;
                rdata[BIT_FLAG] = flag;
            end
            ADR_MLO:  rdata = mlo;
            ADR_MHI:  rdata = mhi;
            default:  rdata[PRIO_BIT] = prio_hi;
        endcase
    end
endmodule

// File: rtl/lstmr_cnt.sv
`timescale 1ns/1ps
// Up-counter with compare; wraps to zero on a match tick.
// Assumes tick is a single-cycle enable pulse in the clk domain.
module lstmr_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tmr_en,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] match,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic running;

    assign running = tmr_en && cnt_en && tick;
    assign hit     = running && (count == match);

    // Advance, hold, wrap on match, or clear when the timer is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !tmr_en) begin
            count <= '0;
        end else if (hit) begin
            count <= '0;
        end else if (running) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/lstmr_flag.sv
`timescale 1ns/1ps
// Sticky match flag and the gated interrupt and wake requests.
// Assumes a match outranks a software clear in the same cycle.
module lstmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic gie,
    input  logic irq_en,
    input  logic tmr_en,
    input  logic cnt_en,
    input  logic wake_en,
    output logic flag,
    output logic irq,
    output logic wake
);
    // Set on a match, clear on software request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    assign irq  = flag && gie && irq_en;
    assign wake = flag && tmr_en && cnt_en && wake_en;
endmodule

// File: rtl/lstmr_top.sv
`timescale 1ns/1ps
// Low-speed compare timer: registers, counter and flag/request logic.
// Assumes clk keeps running in sleep; lsi_tick paces the count.
module lstmr_top
    import lstmr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PRIO_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsi_tick,
    input  logic              gie_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              wake_o,
    output logic              prio_o
);
    localparam int CNT_W = 2 * DATA_W;

    logic             tmr_en, cnt_en, wake_en, irq_en;
    logic             flag, flag_clr, hit;
    logic [CNT_W-1:0] match, count;

    lstmr_regs #(.DATA_W(DATA_W), .PRIO_BIT(PRIO_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .flag(flag), .tmr_en(tmr_en), .cnt_en(cnt_en), .wake_en(wake_en),
        .irq_en(irq_en), .match(match), .prio_hi(prio_o),
        .flag_clr(flag_clr), .rdata(rdata)
    );

    lstmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(lsi_tick), .tmr_en(tmr_en),
        .cnt_en(cnt_en), .match(match), .count(count), .hit(hit)
    );

    lstmr_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hit(hit), .flag_clr(flag_clr),
        .gie(gie_i), .irq_en(irq_en), .tmr_en(tmr_en), .cnt_en(cnt_en),
        .wake_en(wake_en), .flag(flag), .irq(irq_o), .wake(wake_o)
    );
endmodule

// File: rtl/lstmr_chk.sv
`timescale 1ns/1ps
// Property checker for lstmr_top, attached by bind below.
module lstmr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lsi_tick,
    input logic             gie_i,
    input logic [1:0]       addr,
    input logic [7:0]       rdata,
    input logic             irq_o,
    input logic             wake_o,
    input logic             hit,
    input logic             flag,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             tmr_en,
    input logic             cnt_en,
    input logic             wake_en
);
    // R3
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (count == '0));
    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lsi_tick && tmr_en) |=> $stable(count));
    // R5
    irq_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie_i && flag));
    // R6
    wake_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (tmr_en && cnt_en && wake_en && flag));
    // R7
    prio_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |-> (rdata[7:3] == 5'd0 && rdata[1:0] == 2'd0));
endmodule

bind lstmr_top lstmr_chk #(.CNT_W(2 * DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lsi_tick(lsi_tick), .gie_i(gie_i),
    .addr(addr), .rdata(rdata), .irq_o(irq_o), .wake_o(wake_o), .hit(hit),
    .flag(flag), .flag_clr(flag_clr), .count(count), .tmr_en(tmr_en),
    .cnt_en(cnt_en), .wake_en(wake_en)
);

// File: tb/lstmr_top_tb.sv
`timescale 1ns/1ps
module lstmr_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lsi_tick = 1'b0, gie_i = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_o, wake_o, prio_o;

    int checks = 0, failures = 0;
    bit done = 0;

    // Bench model state, derived from the requirements.
    logic        m_ten, m_cen, m_wen, m_ien, m_flag, m_prio;
    logic [7:0]  m_lo, m_hi;
    logic [15:0] m_cnt;

    always #4 clk = ~clk;

    lstmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .lsi_tick(lsi_tick), .gie_i(gie_i),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_o(irq_o), .wake_o(wake_o), .prio_o(prio_o)
    );

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {3'b000, m_flag, m_ien, m_wen, m_cen, m_ten};
            2'd1: return m_lo;
            2'd2: return m_hi;
            default: return {5'b0, m_prio, 2'b00};
        endcase
    endfunction

    function automatic logic [10:0] exp_out(input logic [1:0] a, input logic g);
        return {m_flag & g & m_ien, m_flag & m_ten & m_cen & m_wen, m_prio, exp_rd(a)};
    endfunction

    task automatic model_reset();
        {m_ten, m_cen, m_wen, m_ien, m_flag, m_prio} = '0;
        m_lo = '0; m_hi = '0; m_cnt = '0;
    endtask

    task automatic check(input string tag);
        logic [10:0] act, exp;
        act = {irq_o, wake_o, prio_o, rdata};
        exp = exp_out(addr, gie_i);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, check after it.
    task automatic step(input logic tk, input logic g, input logic w,
                        input logic [1:0] a, input logic [7:0] d, input string tag);
        logic run, hit;
        @(negedge clk);
        lsi_tick = tk; gie_i = g; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        run = m_ten & m_cen & tk;
        hit = run && (m_cnt == {m_hi, m_lo});
        if (!m_ten) m_cnt = '0;
        else if (hit) m_cnt = '0;
        else if (run) m_cnt = m_cnt + 16'd1;
        if (hit) m_flag = 1'b1;
        else if (w && a == 2'd0 && !d[4]) m_flag = 1'b0;
        if (w) begin
            case (a)
                2'd0: {m_ien, m_wen, m_cen, m_ten} = d[3:0];
                2'd1: m_lo = d;
                2'd2: m_hi = d;
                default: m_prio = d[2];
            endcase
        end
        #2;
        check(tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        for (int a = 0; a < 4; a++) begin
            addr = a[1:0];
            #1 check("R1 reset");
        end
        @(negedge clk); rst_n = 1'b1;
        // R1: no ticks counted while disabled
        step(1, 1, 0, 2'd0, 8'h00, "R1 idle");
        // R7: only bit 2 of the priority register sticks
        step(0, 0, 1, 2'd3, 8'hFF, "R7 prio set");
        step(0, 0, 1, 2'd3, 8'hFB, "R7 prio clear");
        step(0, 0, 1, 2'd3, 8'h04, "R7 prio high");
        // R8: match zero fires on the first counting tick
        step(0, 1, 1, 2'd0, 8'h0F, "R9 ctrl write");
        step(1, 1, 0, 2'd0, 8'h00, "R8 match zero");
        // R4: writing 1 to the flag bit keeps it
        step(0, 1, 1, 2'd0, 8'h1F, "R4 write one");
        // R4: writing 0 clears it
        step(0, 1, 1, 2'd0, 8'h0F, "R4 clear");
        // R4: clear colliding with a match keeps the flag
        step(1, 1, 1, 2'd0, 8'h0F, "R4 collision");
        // R5: global enable off masks irq
        step(0, 0, 0, 2'd0, 8'h00, "R5 gie off");
        // R6: wake enable off masks wake, flag remains
        step(0, 1, 1, 2'd0, 8'h1B, "R6 wake off");
        // R3: match 5 gives a flag after six ticks
        step(0, 1, 1, 2'd1, 8'h05, "R9 match lo");
        step(0, 1, 1, 2'd2, 8'h00, "R9 match hi");
        step(0, 1, 1, 2'd0, 8'h0F, "R3 clear");
        for (int i = 0; i < 7; i++) step(1, 1, 0, 2'd0, 8'h00, "R3 period");
        // R2: count enable low holds, timer enable low zeroes
        step(0, 1, 1, 2'd0, 8'h0D, "R2 hold");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 2'd0, 8'h00, "R2 held");
        step(0, 1, 1, 2'd0, 8'h0E, "R2 timer off");
        step(1, 1, 0, 2'd0, 8'h00, "R2 zeroed");
        step(0, 1, 1, 2'd0, 8'h0F, "R2 restart");
        for (int i = 0; i < 7; i++) step(1, 1, 0, 2'd0, 8'h00, "R2 recount");
        // Random phase with small match values.
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            logic       w;
            a = 2'($urandom % 4);
            d = 8'($urandom);
            w = ($urandom % 6) == 0;
            if (a == 2'd2) d = (($urandom % 16) == 0) ? 8'h01 : 8'h00;
            if (a == 2'd1) d = d & 8'h07;
            if (a == 2'd0 && ($urandom % 4) != 0) d[1:0] = 2'b11;
            step(($urandom % 2) == 0, ($urandom % 4) != 0, w, a, d, "R3 R5 R6 random");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule